// File: doc/BRIEF.md
# Hybrid Sector Map and Erase Legality Checker

This block turns a byte address in a 128 MB flash space into the sector that contains it. It reports that sector's index, base address and size. In the same step it decides whether a requested erase may proceed. Two layouts are supported. In the uniform layout every sector spans 256 KB. In the hybrid layout one end of the space holds eight 4 KB parameter sectors and one 224 KB sector, and together they fill exactly one 256 KB slot. The parameter end is chosen with a top/bottom select.

Addresses arrive either as a full 32-bit value or as a 24-bit value. In the 24-bit case a bank input supplies the missing upper bits. Each request is a single-cycle strobe. One clock later the block registers the sector descriptor and raises exactly one of a one-cycle accept pulse or a one-cycle reject pulse. An error-flag unit downstream can consume these pulses.

Top module: `flash_sector_map`

## Requirements
- R1: The effective 27-bit address is `req_addr[26:0]` when `addr_4byte` is 1. When `addr_4byte` is 0 it is `{bank_sel[2:0], req_addr[23:0]}`. All other request address bits are ignored.
- R2: With `hybrid_en` at 0, every sector is 256 KB, reported as size 0x40000. The base is the address with bits 17:0 cleared, and the index is address bits 26:18.
- R3: With `hybrid_en` at 1 and `param_top` at 0, the parameter end is at the bottom of the space.
  - Addresses 0x0000000 to 0x0007FFF form eight 4 KB sectors with indices 0 to 7.
  - Addresses 0x0008000 to 0x003FFFF form the 224 KB sector, with index 8, base 0x0008000 and size 0x38000.
  - Every other 256 KB slot k has index k+8.
- R4: With `hybrid_en` at 1 and `param_top` at 1, the parameter end is at the top of the space.
  - The 256 KB slots 0 to 510 keep index k.
  - Addresses 0x7FC0000 to 0x7FF7FFF form the 224 KB sector, with index 511 and size 0x38000.
  - Addresses 0x7FF8000 to 0x7FFFFFF form 4 KB sectors with indices 512 to 519.
- R5: `erase_op` code 2'b00 is a 4 KB erase. It is accepted only when the address lies inside a 4 KB parameter sector of the hybrid layout. Otherwise it is rejected.
- R6: `erase_op` codes 2'b10 (8 KB area) and 2'b11 (32 KB area) are always rejected. For these codes the descriptor is the smallest sector that contains the address.
- R7: `erase_op` code 2'b01 is a 256 KB sector erase, and it is legal at any address. When it targets the 256 KB slot holding the parameter sectors, the reported sector is the 224 KB sector, with its index, base and size.
- R8: A request with `protect` at 1 is rejected, whatever its other inputs are.
- R9: Timing and reset behaviour:
  - Descriptor, `accept` and `reject` update on the clock edge that samples `req_valid` at 1.
  - `accept` and `reject` are never high together, and each stays high for one cycle only.
  - Neither pulse appears without a request.
  - Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| addr_4byte | input | 1 | 1 selects the 32-bit address form, 0 the 24-bit form |
| bank_sel | input | 3 | Upper address bits used in the 24-bit form |
| hybrid_en | input | 1 | 1 selects the hybrid layout |
| param_top | input | 1 | 1 places the parameter sectors at the top |
| erase_op | input | 2 | 00 = 4 KB, 01 = 256 KB sector, 10 = 8 KB, 11 = 32 KB |
| protect | input | 1 | The target is protected |
| sec_idx | output | 10 | Sector index |
| sec_base | output | 27 | Sector base address |
| sec_size | output | 19 | Sector size in bytes |
| accept | output | 1 | One-cycle pulse: erase legal |
| reject | output | 1 | One-cycle pulse: erase illegal or protected |

## Verification
Addresses are tried at both edges of each parameter sector, of the 224 KB sector and of ordinary 256 KB slots, under the uniform layout and under both parameter placements. Each address is tried with each erase code. The edge cases separate an off-by-one in the 4 KB window from a wrong choice of end, and a wrong index offset from a wrong base. Addresses in the 24-bit and 32-bit forms carry junk in the bits that must be ignored, which exposes wrong concatenation or masking. Protected requests and requests with the 8 KB and 32 KB codes show that rejection overrides an otherwise legal map. Idle cycles that carry illegal inputs show that no pulse appears without a request.

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
  parameter int ADDR_W      = 27,
  parameter int SECT_SHIFT  = 18,
  parameter int SMALL_SHIFT = 12,
  parameter int SMALL_CNT   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        addr_4byte,
  input  logic [2:0]  bank_sel,
  input  logic        hybrid_en,
  input  logic        param_top,
  input  logic [1:0]  erase_op,
  input  logic        protect,
  output logic [9:0]  sec_idx,
  output logic [26:0] sec_base,
  output logic [18:0] sec_size,
  output logic        accept,
  output logic        reject
);
  localparam int BLK_W    = ADDR_W - SECT_SHIFT;
  localparam int SLOT_W   = $clog2(SMALL_CNT);
  localparam int REGION_S = SMALL_SHIFT + SLOT_W;
  localparam int SUB_W    = SECT_SHIFT - REGION_S;
  localparam int SECT_CNT = 1 << BLK_W;
  localparam int IDX_W    = $clog2(SECT_CNT + SMALL_CNT);
  localparam int SIZE_W   = SECT_SHIFT + 1;
  localparam logic [SIZE_W-1:0] BIG_SZ   = SIZE_W'(1) << SECT_SHIFT;
  localparam logic [SIZE_W-1:0] SMALL_SZ = SIZE_W'(1) << SMALL_SHIFT;
  localparam logic [SIZE_W-1:0] MID_SZ   = BIG_SZ - SIZE_W'(SMALL_CNT << SMALL_SHIFT);
  localparam logic [1:0] OP_4K   = 2'b00;
  localparam logic [1:0] OP_SECT = 2'b01;

  logic [ADDR_W-1:0] full_addr;
  logic [BLK_W-1:0]  blk;
  logic [SUB_W-1:0]  sub;
  logic [SLOT_W-1:0] slot;
  logic param_blk, in_small, use_small, use_mid, legal;
  logic [IDX_W-1:0]  nxt_idx;
  logic [ADDR_W-1:0] nxt_base;
  logic [SIZE_W-1:0] nxt_size;

  assign full_addr = addr_4byte ? req_addr[ADDR_W-1:0] : {bank_sel, req_addr[23:0]};
  assign blk       = full_addr[ADDR_W-1:SECT_SHIFT];
  assign sub       = full_addr[SECT_SHIFT-1:REGION_S];
  assign slot      = full_addr[REGION_S-1:SMALL_SHIFT];
  assign param_blk = hybrid_en && (blk == (param_top ? {BLK_W{1'b1}} : {BLK_W{1'b0}}));
  assign in_small  = param_blk && (sub == (param_top ? {SUB_W{1'b1}} : {SUB_W{1'b0}}));
  assign use_small = in_small && (erase_op != OP_SECT);
  assign use_mid   = param_blk && !use_small;
  assign legal     = !protect && !erase_op[1] && ((erase_op == OP_SECT) || in_small);

  always_comb begin
    if (use_small) begin
      nxt_size = SMALL_SZ;
      nxt_base = {full_addr[ADDR_W-1:SMALL_SHIFT], {SMALL_SHIFT{1'b0}}};
      nxt_idx  = param_top ? IDX_W'(SECT_CNT) + IDX_W'(slot) : IDX_W'(slot);
    end else if (use_mid) begin
      nxt_size = MID_SZ;
      nxt_base = param_top ? {blk, {SECT_SHIFT{1'b0}}} : ADDR_W'(SMALL_CNT << SMALL_SHIFT);
      nxt_idx  = param_top ? IDX_W'(SECT_CNT - 1) : IDX_W'(SMALL_CNT);
    end else begin
      nxt_size = BIG_SZ;
      nxt_base = {blk, {SECT_SHIFT{1'b0}}};
      nxt_idx  = (hybrid_en && !param_top) ? IDX_W'(blk) + IDX_W'(SMALL_CNT) : IDX_W'(blk);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_idx  <= '0;
      sec_base <= '0;
      sec_size <= '0;
      accept   <= 1'b0;
      reject   <= 1'b0;
    end else begin
      accept <= req_valid && legal;
      reject <= req_valid && !legal;
      if (req_valid) begin
        sec_idx  <= nxt_idx;
        sec_base <= nxt_base;
        sec_size <= nxt_size;
      end
    end
  end

  assert_addr_in_sector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || reject) && ($past(erase_op) != OP_SECT) |->
      ($past(full_addr) >= sec_base) &&
      (($past(full_addr) - sec_base) < ADDR_W'(sec_size)));

  assert_4k_only_hybrid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ($past(erase_op) == OP_4K) |-> (sec_size == SMALL_SZ) && $past(hybrid_en));

  assert_odd_ops_rejected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && erase_op[1] |=> reject && !accept);

  assert_protect_rejects_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && protect |=> reject && !accept);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject));

  assert_pulse_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || reject) |-> $past(req_valid));
endmodule

// File: tb/flash_sector_map_bench.sv
module flash_sector_map_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic addr_4byte = 1'b1;
  logic [2:0] bank_sel = '0;
  logic hybrid_en = 1'b0;
  logic param_top = 1'b0;
  logic [1:0] erase_op = '0;
  logic protect = 1'b0;
  logic [9:0] sec_idx;
  logic [26:0] sec_base;
  logic [18:0] sec_size;
  logic accept, reject;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_sector_map u_flash_sector_map (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .addr_4byte(addr_4byte), .bank_sel(bank_sel), .hybrid_en(hybrid_en),
    .param_top(param_top), .erase_op(erase_op), .protect(protect),
    .sec_idx(sec_idx), .sec_base(sec_base), .sec_size(sec_size),
    .accept(accept), .reject(reject)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic        a4;
    logic [2:0]  bank;
    logic [31:0] addr;
    logic        hyb;
    logic        top;
    logic [1:0]  op;
    logic        prot;
    logic [9:0]  idx;
    logic [26:0] base;
    logic [18:0] size;
    logic        acc;
    logic        rej;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{"R2", 1'b1, 3'd0, 32'h01234567, 1'b0, 1'b0, 2'd1, 1'b0, 10'd72,  27'h1200000, 19'h40000, 1'b1, 1'b0},
    '{"R5", 1'b1, 3'd0, 32'h00000100, 1'b0, 1'b0, 2'd0, 1'b0, 10'd0,   27'h0000000, 19'h40000, 1'b0, 1'b1},
    '{"R1", 1'b1, 3'd0, 32'hF8000010, 1'b0, 1'b0, 2'd1, 1'b0, 10'd0,   27'h0000000, 19'h40000, 1'b1, 1'b0},
    '{"R1", 1'b0, 3'd5, 32'h12ABCDEF, 1'b0, 1'b0, 2'd1, 1'b0, 10'd362, 27'h5A80000, 19'h40000, 1'b1, 1'b0},
    '{"R3", 1'b1, 3'd0, 32'h00005123, 1'b1, 1'b0, 2'd0, 1'b0, 10'd5,   27'h0005000, 19'h01000, 1'b1, 1'b0},
    '{"R3", 1'b1, 3'd0, 32'h00007FFF, 1'b1, 1'b0, 2'd0, 1'b0, 10'd7,   27'h0007000, 19'h01000, 1'b1, 1'b0},
    '{"R5", 1'b1, 3'd0, 32'h00008000, 1'b1, 1'b0, 2'd0, 1'b0, 10'd8,   27'h0008000, 19'h38000, 1'b0, 1'b1},
    '{"R3", 1'b1, 3'd0, 32'h0003FFFF, 1'b1, 1'b0, 2'd1, 1'b0, 10'd8,   27'h0008000, 19'h38000, 1'b1, 1'b0},
    '{"R3", 1'b1, 3'd0, 32'h00040000, 1'b1, 1'b0, 2'd1, 1'b0, 10'd9,   27'h0040000, 19'h40000, 1'b1, 1'b0},
    '{"R7", 1'b1, 3'd0, 32'h00000000, 1'b1, 1'b0, 2'd1, 1'b0, 10'd8,   27'h0008000, 19'h38000, 1'b1, 1'b0},
    '{"R5", 1'b1, 3'd0, 32'h07FFFFFF, 1'b1, 1'b0, 2'd0, 1'b0, 10'd519, 27'h7FC0000, 19'h40000, 1'b0, 1'b1},
    '{"R4", 1'b1, 3'd0, 32'h07FFFFFF, 1'b1, 1'b1, 2'd0, 1'b0, 10'd519, 27'h7FFF000, 19'h01000, 1'b1, 1'b0},
    '{"R4", 1'b1, 3'd0, 32'h07FF8000, 1'b1, 1'b1, 2'd0, 1'b0, 10'd512, 27'h7FF8000, 19'h01000, 1'b1, 1'b0},
    '{"R5", 1'b1, 3'd0, 32'h07FF7FFF, 1'b1, 1'b1, 2'd0, 1'b0, 10'd511, 27'h7FC0000, 19'h38000, 1'b0, 1'b1},
    '{"R7", 1'b1, 3'd0, 32'h07FFA000, 1'b1, 1'b1, 2'd1, 1'b0, 10'd511, 27'h7FC0000, 19'h38000, 1'b1, 1'b0},
    '{"R5", 1'b1, 3'd0, 32'h00000000, 1'b1, 1'b1, 2'd0, 1'b0, 10'd0,   27'h0000000, 19'h40000, 1'b0, 1'b1},
    '{"R4", 1'b1, 3'd0, 32'h07FBFFFF, 1'b1, 1'b1, 2'd1, 1'b0, 10'd510, 27'h7F80000, 19'h40000, 1'b1, 1'b0},
    '{"R6", 1'b1, 3'd0, 32'h00001000, 1'b1, 1'b0, 2'd2, 1'b0, 10'd1,   27'h0001000, 19'h01000, 1'b0, 1'b1},
    '{"R6", 1'b1, 3'd0, 32'h00040000, 1'b0, 1'b0, 2'd3, 1'b0, 10'd1,   27'h0040000, 19'h40000, 1'b0, 1'b1},
    '{"R8", 1'b1, 3'd0, 32'h00002000, 1'b1, 1'b0, 2'd0, 1'b1, 10'd2,   27'h0002000, 19'h01000, 1'b0, 1'b1},
    '{"R8", 1'b1, 3'd0, 32'h00080000, 1'b0, 1'b0, 2'd1, 1'b1, 10'd2,   27'h0080000, 19'h40000, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [57:0] act, input logic [57:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual idx=%0d base=%h size=%h acc=%b rej=%b expected idx=%0d base=%h size=%h acc=%b rej=%b",
               req, act[57:48], act[47:21], act[20:2], act[1], act[0],
               exp[57:48], exp[47:21], exp[20:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", {sec_idx, sec_base, sec_size, accept, reject}, 58'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      addr_4byte = VECS[i].a4;
      bank_sel   = VECS[i].bank;
      req_addr   = VECS[i].addr;
      hybrid_en  = VECS[i].hyb;
      param_top  = VECS[i].top;
      erase_op   = VECS[i].op;
      protect    = VECS[i].prot;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid  = 1'b0;
      check(string'(VECS[i].tag), {sec_idx, sec_base, sec_size, accept, reject},
            {VECS[i].idx, VECS[i].base, VECS[i].size, VECS[i].acc, VECS[i].rej});
    end
    // R9: pulse lasts one cycle, descriptor holds
    @(negedge clk);
    check("R9 pulse end", {sec_idx, sec_base, sec_size, accept, reject},
          {10'd2, 27'h0080000, 19'h40000, 1'b0, 1'b0});
    // R9: illegal inputs without a request produce no pulse
    erase_op = 2'd3;
    protect  = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 idle", {sec_idx, sec_base, sec_size, accept, reject},
          {10'd2, 27'h0080000, 19'h40000, 1'b0, 1'b0});
    // R9: back-to-back requests give two pulses in consecutive cycles
    protect = 1'b0; erase_op = 2'd1; hybrid_en = 1'b0; req_addr = 32'h000C0000;
    req_valid = 1'b1;
    @(negedge clk);
    check("R9 b2b first", {sec_idx, sec_base, sec_size, accept, reject},
          {10'd3, 27'h00C0000, 19'h40000, 1'b1, 1'b0});
    erase_op = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 b2b second", {sec_idx, sec_base, sec_size, accept, reject},
          {10'd3, 27'h00C0000, 19'h40000, 1'b0, 1'b1});
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule